// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Access Sequencer

This block sits between a memory-mapped bus port and a byte-wide SPI shifter. A bus read or write of one to four bytes, aimed at one of several flash devices, is turned into the full serial byte sequence for that device. The sequence is an opcode byte, a three- or four-byte flash address, optional dummy bytes, and then the data bytes. The block frames the sequence with that device's active-low select line. Each device has a 32-bit control word supplied by the surrounding register file. That word picks one of four behaviours: plain read, fast read, program (write), or a raw pass-through mode. In raw mode the bus data goes straight to the wire and software drives the select line itself.

Each device is mapped to a power-of-two window. Flash offsets wrap inside that window before they are sent. Writes are honoured only when that device's write-enable bit is set in a shared configuration word. The bus side is a single-request, single-acknowledge port. A busy flag is high from acceptance until the acknowledge cycle. The serial clock generator and any bulk-transfer engine belong to other blocks.

Top module: `spi_flash_seq`

## Requirements
- R1: With the mode field (control bits [1:0]) equal to 0 (read), the opcode byte is always 0x03, whatever control bits [23:16] hold.
- R2: In modes 1 (fast read) and 2 (write), the opcode byte is control bits [23:16].
- R3: When control bit 13 is 1, the address goes out as four bytes, most significant first. When bit 13 is 0, it goes out as three bytes carrying address bits [23:0], most significant first.
- R4: The number of dummy bytes is ({bit14, bits[7:6]}) × 8. It is halved when control bit 28 is set.
- R5: Dummy bytes are emitted only in fast-read mode, and each carries the value on `dummy_byte`. A read-mode access with nonzero dummy fields sends none.
- R6: For modes 0–2, the selected device's `cs_n` goes low before the opcode byte. It stays low through every byte of the sequence and returns high in the cycle after the last data byte. All other `cs_n` lines stay high.
- R7: In mode 3, only the data bytes are sent, with no opcode, address or dummy phase. A read sends 0x00 per byte. Each `cs_n` line follows the stop bit (control bit 2) of its device, one cycle late.
- R8: Data is little-endian: access byte i is bus bits [8i+7:8i]. Byte 0 goes out or comes in first.
- R9: A write is dropped when configuration bit 16 + device index is 0. No byte is sent, and `bus_ack` rises in the cycle after acceptance.
- R10: The flash address is taken modulo 2^`win_log2` of the device before it is sent.
- R11: `busy` is high from the cycle after acceptance through the acknowledge cycle. `bus_ack` is a one-cycle pulse in the cycle after the last byte's handshake. A shifter request holds its byte stable until `sh_done`.
- R12: During and directly after reset, every `cs_n` line is high, `busy` is 0 and `bus_ack` is 0.
- R13: A write in mode 0 or 1 is dropped like R9. A read in mode 2 sends no byte and acknowledges with read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, taken when `busy` is low |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cs | input | CS_W | Target device index |
| bus_addr | input | 32 | Flash offset of the access |
| bus_size | input | SZ_W | Access length in bytes, 1 to DATA_BYTES |
| bus_wdata | input | 8*DATA_BYTES | Write data, little-endian |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 8*DATA_BYTES | Read data, valid with `bus_ack` |
| busy | output | 1 | Sequence in progress |
| ctl_regs | input | 32*NUM_CS | Per-device control words, device i in bits [32i+31:32i] |
| cfg_reg | input | 32 | Configuration word holding write-enable bits |
| dummy_byte | input | 8 | Value sent in each dummy byte |
| win_log2 | input | 5*NUM_CS | Per-device log2 of the window size |
| sh_req | output | 1 | Byte exchange request to the shifter |
| sh_tx | output | 8 | Byte to send |
| sh_done | input | 1 | Shifter has exchanged the byte |
| sh_rx | input | 8 | Byte received, valid with `sh_done` |
| cs_n | output | NUM_CS | Active-low device selects |

## Verification
A request driven at a falling edge is accepted at the next rising edge. A skipped access (R9, R13) shows `bus_ack` at the very next falling edge. Every shifter byte is exchanged on the rising edge after the bench raises `sh_done`. `bus_ack` must then be seen exactly one cycle after the last such exchange, and `cs_n` must already be released at that point. The bench counts rising edges and compares the acknowledge cycle against that count. Byte values and `cs_n` levels are compared at the falling edge where the bench answers each request.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

   typedef enum logic [1:0] {
      MD_READ  = 2'd0,
      MD_FAST  = 2'd1,
      MD_WRITE = 2'd2,
      MD_USER  = 2'd3
   } seq_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_ADDR,
      ST_DUMMY,
      ST_DATA,
      ST_FIN
   } seq_state_e;

   // control word field positions
   localparam int CTL_STOP_BIT  = 2;
   localparam int CTL_DLO_LSB   = 6;
   localparam int CTL_WIDE_BIT  = 13;
   localparam int CTL_DHI_BIT   = 14;
   localparam int CTL_OP_LSB    = 16;
   localparam int CTL_DUAL_BIT  = 28;

   localparam logic [7:0] PLAIN_READ_OP = 8'h03;

   typedef struct packed {
      seq_mode_e   mode;
      logic [7:0]  opcode;
      logic        wide;
      logic [5:0]  ndum;
      logic [31:0] faddr;
      logic        skip;
   } seq_plan_t;

endpackage

// File: rtl/spi_seq_decode.sv
module spi_seq_decode
   import spi_seq_pkg::*;
#(
   parameter int NUM_CS   = 2,
   parameter int CS_W     = 1,
   parameter int WEN_BASE = 16
) (
   input  logic [31:0]     ctl_word,
   input  logic [31:0]     cfg_word,
   input  logic [CS_W-1:0] cs_idx,
   input  logic            we,
   input  logic [31:0]     addr,
   input  logic [4:0]      log2_sz,
   output seq_plan_t       plan
);

   logic [NUM_CS-1:0] wen_bits;
   logic [5:0]        dum_raw;
   logic [31:0]       win_mask;
   seq_mode_e         md;

   assign wen_bits = cfg_word[WEN_BASE +: NUM_CS];
   assign md       = seq_mode_e'(ctl_word[1:0]);
   assign dum_raw  = {ctl_word[CTL_DHI_BIT], ctl_word[CTL_DLO_LSB +: 2], 3'b000};
   assign win_mask = ~(32'hFFFF_FFFF << log2_sz);

   always_comb begin
      plan.mode   = md;
      plan.opcode = (md == MD_READ) ? PLAIN_READ_OP : ctl_word[CTL_OP_LSB +: 8];
      plan.wide   = ctl_word[CTL_WIDE_BIT];
      plan.faddr  = addr & win_mask;
      if (md == MD_FAST) begin
         plan.ndum = ctl_word[CTL_DUAL_BIT] ? (dum_raw >> 1) : dum_raw;
      end else begin
         plan.ndum = 6'd0;
      end
      if (we) begin
         plan.skip = !wen_bits[cs_idx] || (md == MD_READ) || (md == MD_FAST);
      end else begin
         plan.skip = (md == MD_WRITE);
      end
   end

endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
   import spi_seq_pkg::*;
#(
   parameter int DATA_BYTES = 4,
   parameter int CS_W       = 1,
   parameter int SZ_W       = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_req,
   input  logic                    bus_we,
   input  logic [CS_W-1:0]         bus_cs,
   input  logic [SZ_W-1:0]         bus_size,
   input  logic [8*DATA_BYTES-1:0] bus_wdata,
   input  seq_plan_t               plan,
   input  logic [7:0]              dummy_byte,
   input  logic                    sh_done,
   input  logic [7:0]              sh_rx,
   output logic                    busy,
   output logic                    bus_ack,
   output logic [8*DATA_BYTES-1:0] bus_rdata,
   output logic                    sh_req,
   output logic [7:0]              sh_tx,
   output logic                    frame_nx,
   output logic [CS_W-1:0]         cs_nx
);

   localparam int LANE_W = $clog2(DATA_BYTES);
   localparam int DW     = 8 * DATA_BYTES;

   seq_state_e        st_q, st_nx;
   seq_plan_t         pl_q;
   logic              we_q;
   logic [CS_W-1:0]   cs_q;
   logic [LANE_W-1:0] last_q, last_in;
   logic [DW-1:0]     wdata_q, rdata_q;
   logic [7:0]        ddat_q;
   logic [5:0]        cnt_q;
   logic              accept, hs, phase_end;
   logic [1:0]        abyte_idx;
   logic [LANE_W-1:0] lane;
   seq_mode_e         mode_nx;

   assign accept    = bus_req && (st_q == ST_IDLE);
   assign hs        = sh_req && sh_done;
   assign lane      = cnt_q[LANE_W-1:0];
   assign abyte_idx = (pl_q.wide ? 2'd3 : 2'd2) - cnt_q[1:0];

   always_comb begin
      if (bus_size == '0) begin
         last_in = '0;
      end else if (bus_size > SZ_W'(DATA_BYTES)) begin
         last_in = LANE_W'(DATA_BYTES - 1);
      end else begin
         last_in = LANE_W'(bus_size - SZ_W'(1));
      end
   end

   always_comb begin
      st_nx = st_q;
      unique case (st_q)
         ST_IDLE: if (accept) begin
            if (plan.skip)                st_nx = ST_FIN;
            else if (plan.mode == MD_USER) st_nx = ST_DATA;
            else                          st_nx = ST_CMD;
         end
         ST_CMD:   if (hs) st_nx = ST_ADDR;
         ST_ADDR:  if (hs && cnt_q == (pl_q.wide ? 6'd3 : 6'd2))
                      st_nx = (pl_q.ndum != 6'd0) ? ST_DUMMY : ST_DATA;
         ST_DUMMY: if (hs && cnt_q == pl_q.ndum - 6'd1) st_nx = ST_DATA;
         ST_DATA:  if (hs && cnt_q == 6'(last_q)) st_nx = ST_FIN;
         ST_FIN:   st_nx = ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   assign phase_end = (st_nx != st_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         pl_q    <= '0;
         we_q    <= 1'b0;
         cs_q    <= '0;
         last_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         ddat_q  <= '0;
         cnt_q   <= '0;
      end else begin
         st_q <= st_nx;
         if (accept) begin
            pl_q    <= plan;
            we_q    <= bus_we;
            cs_q    <= bus_cs;
            last_q  <= last_in;
            wdata_q <= bus_wdata;
            ddat_q  <= dummy_byte;
            rdata_q <= '0;
         end
         if (st_q == ST_DATA && hs && !we_q) begin
            rdata_q[lane*8 +: 8] <= sh_rx;
         end
         if (phase_end)  cnt_q <= '0;
         else if (hs)    cnt_q <= cnt_q + 6'd1;
      end
   end

   always_comb begin
      unique case (st_q)
         ST_CMD:   sh_tx = pl_q.opcode;
         ST_ADDR:  sh_tx = 8'(pl_q.faddr >> {abyte_idx, 3'b000});
         ST_DUMMY: sh_tx = ddat_q;
         ST_DATA:  sh_tx = we_q ? 8'(wdata_q >> {lane, 3'b000}) : 8'h00;
         default:  sh_tx = 8'h00;
      endcase
   end

   assign sh_req    = (st_q == ST_CMD) || (st_q == ST_ADDR) ||
                      (st_q == ST_DUMMY) || (st_q == ST_DATA);
   assign busy      = (st_q != ST_IDLE);
   assign bus_ack   = (st_q == ST_FIN);
   assign bus_rdata = rdata_q;

   assign mode_nx  = accept ? plan.mode : pl_q.mode;
   assign cs_nx    = accept ? bus_cs : cs_q;
   assign frame_nx = ((st_nx == ST_CMD) || (st_nx == ST_ADDR) ||
                      (st_nx == ST_DUMMY) || (st_nx == ST_DATA)) &&
                     (mode_nx != MD_USER);

endmodule

// File: rtl/spi_seq_csgen.sv
module spi_seq_csgen #(
   parameter int NUM_CS = 2,
   parameter int CS_W   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_nx,
   input  logic [CS_W-1:0]   cs_nx,
   input  logic [NUM_CS-1:0] stop_bits,
   output logic [NUM_CS-1:0] cs_n
);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cs_n[i] <= 1'b1;
         end else if (frame_nx && cs_nx == CS_W'(i)) begin
            cs_n[i] <= 1'b0;
         end else begin
            cs_n[i] <= stop_bits[i];
         end
      end
   end

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
   import spi_seq_pkg::*;
#(
   parameter int NUM_CS     = 2,
   parameter int DATA_BYTES = 4,
   parameter int WEN_BASE   = 16,
   localparam int CS_W      = $clog2(NUM_CS),
   localparam int SZ_W      = $clog2(DATA_BYTES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_req,
   input  logic                    bus_we,
   input  logic [CS_W-1:0]         bus_cs,
   input  logic [31:0]             bus_addr,
   input  logic [SZ_W-1:0]         bus_size,
   input  logic [8*DATA_BYTES-1:0] bus_wdata,
   output logic                    bus_ack,
   output logic [8*DATA_BYTES-1:0] bus_rdata,
   output logic                    busy,
   input  logic [32*NUM_CS-1:0]    ctl_regs,
   input  logic [31:0]             cfg_reg,
   input  logic [7:0]              dummy_byte,
   input  logic [5*NUM_CS-1:0]     win_log2,
   output logic                    sh_req,
   output logic [7:0]              sh_tx,
   input  logic                    sh_done,
   input  logic [7:0]              sh_rx,
   output logic [NUM_CS-1:0]       cs_n
);

   if (NUM_CS < 2 || (NUM_CS & (NUM_CS - 1)) != 0 || WEN_BASE + NUM_CS > 32) begin : g_bad_cs
      initial $fatal(1, "NUM_CS must be a power of two fitting the enable field");
   end
   if (DATA_BYTES < 2 || DATA_BYTES > 4) begin : g_bad_bytes
      initial $fatal(1, "DATA_BYTES must be 2 to 4");
   end

   logic [31:0]       ctl_arr [NUM_CS];
   logic [4:0]        lg_arr  [NUM_CS];
   logic [NUM_CS-1:0] stop_bits;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_split
      assign ctl_arr[i]   = ctl_regs[32*i +: 32];
      assign lg_arr[i]    = win_log2[5*i +: 5];
      assign stop_bits[i] = ctl_regs[32*i + CTL_STOP_BIT];
   end

   seq_plan_t       plan;
   logic            frame_nx;
   logic [CS_W-1:0] cs_nx;

   spi_seq_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W), .WEN_BASE(WEN_BASE)) u_dec (
      .ctl_word (ctl_arr[bus_cs]),
      .cfg_word (cfg_reg),
      .cs_idx   (bus_cs),
      .we       (bus_we),
      .addr     (bus_addr),
      .log2_sz  (lg_arr[bus_cs]),
      .plan     (plan)
   );

   spi_seq_fsm #(.DATA_BYTES(DATA_BYTES), .CS_W(CS_W), .SZ_W(SZ_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_req    (bus_req),
      .bus_we     (bus_we),
      .bus_cs     (bus_cs),
      .bus_size   (bus_size),
      .bus_wdata  (bus_wdata),
      .plan       (plan),
      .dummy_byte (dummy_byte),
      .sh_done    (sh_done),
      .sh_rx      (sh_rx),
      .busy       (busy),
      .bus_ack    (bus_ack),
      .bus_rdata  (bus_rdata),
      .sh_req     (sh_req),
      .sh_tx      (sh_tx),
      .frame_nx   (frame_nx),
      .cs_nx      (cs_nx)
   );

   spi_seq_csgen #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cs (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_nx  (frame_nx),
      .cs_nx     (cs_nx),
      .stop_bits (stop_bits),
      .cs_n      (cs_n)
   );

endmodule

// File: rtl/spi_flash_seq_chk.sv
module spi_flash_seq_chk #(
   parameter int NUM_CS   = 2,
   parameter int CS_W     = 1,
   parameter int WEN_BASE = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [CS_W-1:0]   bus_cs,
   input logic [31:0]       cfg_reg,
   input logic              busy,
   input logic              bus_ack,
   input logic              sh_req,
   input logic              sh_done,
   input logic [7:0]        sh_tx
);

   logic [NUM_CS-1:0] wen_bits;
   assign wen_bits = cfg_reg[WEN_BASE +: NUM_CS];

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> (!bus_ack && !busy)); // R11

   AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      sh_req |-> (busy && !bus_ack)); // R11

   AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_req && !sh_done) |=> (sh_req && $stable(sh_tx))); // R11

   AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_ack); // R12

   AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !busy && bus_we && !wen_bits[bus_cs]) |=> (bus_ack && !sh_req)); // R9

endmodule

bind spi_flash_seq spi_flash_seq_chk #(.NUM_CS(NUM_CS), .CS_W(CS_W), .WEN_BASE(WEN_BASE)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_req (bus_req),
   .bus_we  (bus_we),
   .bus_cs  (bus_cs),
   .cfg_reg (cfg_reg),
   .busy    (busy),
   .bus_ack (bus_ack),
   .sh_req  (sh_req),
   .sh_done (sh_done),
   .sh_tx   (sh_tx)
);

// File: tb/spi_flash_seq_tb.sv
module spi_flash_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [0:0]  bus_cs = '0;
   logic [31:0] bus_addr = '0;
   logic [2:0]  bus_size = 3'd1;
   logic [31:0] bus_wdata = '0;
   logic        bus_ack;
   logic [31:0] bus_rdata;
   logic        busy;
   logic [63:0] ctl_regs = {32'h4, 32'h4};
   logic [31:0] cfg_reg = 32'h0001_0000;
   logic [7:0]  dummy_byte = 8'hFF;
   logic [9:0]  win_log2 = {5'd20, 5'd24};
   logic        sh_req;
   logic [7:0]  sh_tx;
   logic        sh_done = 1'b0;
   logic [7:0]  sh_rx = '0;
   logic [1:0]  cs_n;

   always #2 clk = ~clk;

   spi_flash_seq u_dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_cs(bus_cs),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy),
      .ctl_regs(ctl_regs), .cfg_reg(cfg_reg), .dummy_byte(dummy_byte),
      .win_log2(win_log2), .sh_req(sh_req), .sh_tx(sh_tx), .sh_done(sh_done),
      .sh_rx(sh_rx), .cs_n(cs_n)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int last_hs = 0;
   int cur_cs = 0;
   bit cur_framed = 1'b1;
   bit cur_stop = 1'b1;
   logic [7:0] rx_ctr = 8'h21;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] rx_log[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   task automatic push(input logic [7:0] b, input string t);
      exp_q.push_back(b);
      tag_q.push_back(t);
   endtask

   // monitor: plays the shifter and pops the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (sh_done) begin
            sh_done = 1'b0;
         end else if (sh_req) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6", "unexpected shifter byte", {24'h0, sh_tx}, 32'h0);
            end else begin
               logic [7:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(sh_tx == e, t, "shifter byte", {24'h0, sh_tx}, {24'h0, e});
            end
            if (cur_framed)
               chk(cs_n == ~(2'b01 << cur_cs), "R6", "cs_n during frame",
                   {30'h0, cs_n}, {30'h0, ~(2'b01 << cur_cs)});
            else
               chk(cs_n[cur_cs] == cur_stop, "R7", "cs_n in user mode",
                   {31'h0, cs_n[cur_cs]}, {31'h0, cur_stop});
            sh_rx = rx_ctr;
            rx_log.push_back(rx_ctr);
            rx_ctr = rx_ctr + 8'h13;
            sh_done = 1'b1;
            last_hs = cyc;
         end
      end
   end

   task automatic set_ctl(input int cs, input logic [31:0] v);
      ctl_regs[cs*32 +: 32] = v;
   endtask

   // driver: builds the expected byte stream from the requirements
   task automatic access(input int cs, input bit we, input logic [31:0] addr,
                         input int size, input logic [31:0] wd, input string rq);
      logic [31:0] ctl, fa, exp_rd;
      int          md, nb, nd, req_cyc, n;
      bit          skip;
      ctl = ctl_regs[cs*32 +: 32];
      md  = int'(ctl[1:0]);
      skip = we ? (!cfg_reg[16+cs] || md < 2) : (md == 2);
      cur_cs = cs;
      cur_framed = (md != 3);
      cur_stop = ctl[2];
      rx_log.delete();
      if (!skip) begin
         if (md != 3) begin
            push((md == 0) ? 8'h03 : ctl[23:16], (md == 0) ? "R1" : "R2");
            fa = addr & ~(32'hFFFF_FFFF << win_log2[cs*5 +: 5]);
            nb = ctl[13] ? 4 : 3;
            for (int k = 0; k < nb; k++) push(8'(fa >> (8*(nb-1-k))), "R3/R10");
            if (md == 1) begin
               nd = int'({ctl[14], ctl[7:6]}) * 8;
               if (ctl[28]) nd = nd / 2;
               for (int k = 0; k < nd; k++) push(dummy_byte, "R4/R5");
            end
         end
         for (int i = 0; i < size; i++) push(we ? wd[8*i +: 8] : 8'h00, "R8");
      end
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_cs = 1'(cs); bus_addr = addr;
      bus_size = 3'(size); bus_wdata = wd;
      req_cyc = cyc;
      @(negedge clk);
      bus_req = 1'b0;
      n = 0;
      while (!bus_ack && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(bus_ack, "R11", {rq, " ack seen"}, {31'h0, bus_ack}, 32'h1);
      chk(cyc == (skip ? req_cyc : last_hs) + 1, "R11", {rq, " ack cycle"},
          cyc, (skip ? req_cyc : last_hs) + 1);
      exp_rd = '0;
      if (!we && !skip)
         for (int i = 0; i < size; i++) exp_rd[8*i +: 8] = rx_log[rx_log.size() - size + i];
      chk(bus_rdata == exp_rd, "R8", {rq, " read data"}, bus_rdata, exp_rd);
      chk(exp_q.size() == 0, "R6", {rq, " bytes left over"}, exp_q.size(), 0);
      if (cur_framed && !skip)
         chk(cs_n[cs] == 1'b1, "R6", {rq, " cs released at ack"}, {31'h0, cs_n[cs]}, 32'h1);
      exp_q.delete();
      tag_q.delete();
      @(negedge clk);
      chk(!busy, "R11", {rq, " busy clear after ack"}, {31'h0, busy}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "R11", "watchdog expired", 32'h0, 32'h1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n == 2'b11, "R12", "cs_n in reset", {30'h0, cs_n}, 32'h3);
      chk(!busy && !bus_ack, "R12", "busy/ack in reset", {30'h0, busy, bus_ack}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n == 2'b11, "R12", "cs_n after reset", {30'h0, cs_n}, 32'h3);

      // R1 R5: read mode ignores opcode field and dummy fields
      set_ctl(0, 32'h000B_4044);
      access(0, 1'b0, 32'h0012_3456, 4, 32'h0, "R1 plain read");
      // R2 R3 R4: fast read, 4-byte address, 8 dummies
      set_ctl(0, 32'h000C_2045);
      dummy_byte = 8'hFF;
      access(0, 1'b0, 32'h00AB_CDEF, 2, 32'h0, "R4 fast read");
      // R4 R5: dual I/O halves 40 to 20 dummies
      set_ctl(0, 32'h103B_4045);
      dummy_byte = 8'hC3;
      access(0, 1'b0, 32'h0000_0100, 1, 32'h0, "R5 fast dual");
      // R4: zero dummy fields in fast read
      set_ctl(0, 32'h000B_0005);
      access(0, 1'b0, 32'h0000_0010, 1, 32'h0, "R4 no dummies");
      // R3 R10: wide address wraps in a 16 MB window
      set_ctl(0, 32'h0000_2004);
      access(0, 1'b0, 32'hFF80_1234, 3, 32'h0, "R10 wide wrap");
      // R2 R8 R10: write
      set_ctl(0, 32'h0002_0006);
      access(0, 1'b1, 32'h01FF_0010, 3, 32'h0033_2211, "R8 write");
      // R9: device 1 not enabled, then enabled
      set_ctl(1, 32'h0002_0006);
      access(1, 1'b1, 32'h0000_0040, 2, 32'h0000_BEEF, "R9 blocked write");
      cfg_reg = 32'h0003_0000;
      access(1, 1'b1, 32'h00F5_4321, 4, 32'hDEAD_BEEF, "R9 enabled write");
      // R7: user mode, software-held select
      set_ctl(1, 32'h0000_0003);
      @(negedge clk);
      @(negedge clk);
      chk(cs_n == 2'b01, "R7", "stop bit low selects", {30'h0, cs_n}, 32'h1);
      access(1, 1'b0, 32'h0000_0000, 2, 32'h0, "R7 user read");
      chk(cs_n[1] == 1'b0, "R7", "select held after user read", {31'h0, cs_n[1]}, 32'h0);
      access(1, 1'b1, 32'h0000_0000, 1, 32'h0000_00A7, "R7 user write");
      set_ctl(1, 32'h0000_0007);
      @(negedge clk);
      @(negedge clk);
      chk(cs_n == 2'b11, "R7", "stop bit high releases", {30'h0, cs_n}, 32'h3);
      // R13: mode mismatches
      set_ctl(0, 32'h0000_0004);
      access(0, 1'b1, 32'h0000_0020, 2, 32'h0000_1234, "R13 write in read mode");
      set_ctl(0, 32'h0002_0006);
      access(0, 1'b0, 32'h0000_0020, 4, 32'h0, "R13 read in write mode");
      chk(cs_n == 2'b11, "R13", "no select on skipped access", {30'h0, cs_n}, 32'h3);
      report();
   end

endmodule